// File: doc/BRIEF.md
# Two-Source Vectored Interrupt Controller

This block arbitrates interrupts for a small 8-bit processor core. It serves two sources: an asynchronous, active-low external interrupt pin and a one-cycle overflow strobe from a timer/counter. One byte-wide control register holds the master enable, one enable for each source and one pending flag for each source. The core reads and writes this register over a simple data-memory port.

Pending requests are only considered in the cycle in which the core asserts its instruction-phase tick. When an enabled request is pending in that cycle and the return stack has room, the block picks the winner by fixed priority and clears the master enable and the winner's flag. In the following cycle it pulses an acknowledge together with the handler's vector address. The core reports routine exits with one of two strobes. The enabling return sets the master enable again. The plain return leaves the master enable as it is.

The control is a three-state machine. `ST_IDLE` means no handler is running. `ST_GRANT` is the single cycle of the acknowledge pulse. `ST_HANDLER` means a handler is running. The transitions are:
- IDLE→GRANT on a grant decision.
- GRANT→HANDLER always.
- HANDLER→GRANT on a nested grant decision.
- HANDLER→IDLE on either return strobe.

Top module: `twin_irq_ctl`

## Requirements
- R1: After reset the control register reads 0x00, `ack` is 0 and `in_handler` is 0.
- R2: The control register sits at address 0x0B. Its layout is: bit0 master enable, bit1 external enable, bit2 timer enable, bit4 external flag, bit5 timer flag. Bits 3, 6 and 7 read 0. Any other address reads 0x00, and writes to it change nothing.
- R3: The external flag is set by a falling edge of the synchronized `ext_irq_n`. The timer flag is set by `tmr_ovf`.
- R4: A grant is only decided in a cycle with `phase_tick`=1, using the flag values registered before that cycle. A flag set in the tick cycle itself waits for the next tick.
- R5: A source is granted only if the master enable and that source's enable are both 1. A masked flag stays set.
- R6: If both sources are eligible, the external source wins. The external vector is 0x04 and the timer vector is 0x08.
- R7: `ack` is high for exactly one cycle, the cycle after the tick, with `vector` valid. The grant clears the master enable and the granted source's flag.
- R8: `stack_full`=1 in the tick cycle blocks the grant, and the flags are kept.
- R9: `ret_en` sets the master enable. `ret_plain` leaves the master enable unchanged. Either return strobe ends `in_handler`.
- R10: A hardware flag set beats a software write of 0 to that flag in the same cycle.
- R11: `in_handler` is 1 from the acknowledge cycle until a return. Inside a handler, a further grant happens only after software sets the master enable again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ext_irq_n | input | 1 | Asynchronous external interrupt, active low |
| tmr_ovf | input | 1 | Timer overflow strobe |
| phase_tick | input | 1 | Instruction-phase sampling tick |
| stack_full | input | 1 | Return stack has no free entry |
| ret_en | input | 1 | Return that re-enables interrupts |
| ret_plain | input | 1 | Return that leaves the master enable unchanged |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Data address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational |
| ack | output | 1 | Acknowledge pulse |
| vector | output | VEC_W | Handler address, valid with `ack` |
| in_handler | output | 1 | A handler is running |

## Verification
The assertions rely on four assumptions about the inputs:
- `phase_tick`, `tmr_ovf` and the return strobes are one-cycle pulses.
- `ret_en` and `ret_plain` are never asserted together.
- A return does not arrive in the same cycle as a grant.
- `ext_irq_n` holds each level for several cycles.

The stimulus drives every strobe for exactly one clock, separated by idle cycles. Returns are issued only after the acknowledge has been observed. The external pin is held low for five cycles before it is released.

// File: rtl/twin_irq_pkg.sv
package twin_irq_pkg;
    localparam int CTL_W   = 8;
    localparam int B_MEN   = 0;
    localparam int B_EXTEN = 1;
    localparam int B_TMREN = 2;
    localparam int B_EXTFL = 4;
    localparam int B_TMRFL = 5;
    localparam logic [CTL_W-1:0] CTL_MASK =
        CTL_W'((1 << B_MEN) | (1 << B_EXTEN) | (1 << B_TMREN) |
               (1 << B_EXTFL) | (1 << B_TMRFL));

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_GRANT   = 2'd1,
        ST_HANDLER = 2'd2
    } tic_state_e;

    typedef enum logic {
        SRC_EXT = 1'b0,
        SRC_TMR = 1'b1
    } tic_src_e;
endpackage

// File: rtl/tic_edge_sync.sv
module tic_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic fall
);
    logic [STAGES-1:0] stage_q;
    logic              last_q;

    if (STAGES == 1) begin : g_single
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q <= '1;
            else        stage_q <= pin;
        end
    end else begin : g_chain
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q <= '1;
            else        stage_q <= {stage_q[STAGES-2:0], pin};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last_q <= 1'b1;
        else        last_q <= stage_q[STAGES-1];
    end

    assign fall = last_q & ~stage_q[STAGES-1];

    // R3: a falling edge yields one pulse only
    p_fall_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);
endmodule

// File: rtl/tic_ctl_reg.sv
module tic_ctl_reg
    import twin_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CTL_W-1:0] wdata,
    input  logic             ext_set,
    input  logic             tmr_set,
    input  logic             take,
    input  tic_src_e         take_src,
    input  logic             ret_en,
    input  logic             ret_plain,
    output logic [CTL_W-1:0] ctl_q
);
    logic [CTL_W-1:0] ctl_d;

    always_comb begin
        ctl_d = ctl_q;
        if (wr_en) ctl_d = wdata & CTL_MASK;
        if (ret_en) ctl_d[B_MEN] = 1'b1;
        if (take) begin
            ctl_d[B_MEN] = 1'b0;
            if (take_src == SRC_EXT) ctl_d[B_EXTFL] = 1'b0;
            else                     ctl_d[B_TMRFL] = 1'b0;
        end
        // hardware sets take precedence over writes and grant clears
        if (ext_set) ctl_d[B_EXTFL] = 1'b1;
        if (tmr_set) ctl_d[B_TMRFL] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    // R7: a grant leaves the master enable cleared
    p_grant_clears_men_r7: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !ctl_q[B_MEN]);
    // R9: enabling return sets the master enable
    p_ret_en_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_en && !take) |=> ctl_q[B_MEN]);
    // R9: plain return alone leaves the master enable unchanged
    p_ret_plain_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_plain && !ret_en && !take && !wr_en) |=> $stable(ctl_q[B_MEN]));
    // R10: hardware set always lands
    p_tmr_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_set |=> ctl_q[B_TMRFL]);
    p_ext_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ext_set |=> ctl_q[B_EXTFL]);
endmodule

// File: rtl/tic_grant_fsm.sv
module tic_grant_fsm
    import twin_irq_pkg::*;
#(
    parameter int              VEC_W   = 8,
    parameter logic [VEC_W-1:0] VEC_EXT = 8'h04,
    parameter logic [VEC_W-1:0] VEC_TMR = 8'h08
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             phase_tick,
    input  logic             stack_full,
    input  logic             men,
    input  logic             ext_en,
    input  logic             tmr_en,
    input  logic             ext_fl,
    input  logic             tmr_fl,
    input  logic             ret_en,
    input  logic             ret_plain,
    output logic             take,
    output tic_src_e         take_src,
    output logic             ack,
    output logic [VEC_W-1:0] vector,
    output logic             in_handler
);
    tic_state_e       state_q, state_d;
    logic [VEC_W-1:0] vec_q;
    logic             cand_ext, cand_tmr;

    assign cand_ext = men & ext_en & ext_fl;
    assign cand_tmr = men & tmr_en & tmr_fl;
    assign take     = phase_tick & ~stack_full & (cand_ext | cand_tmr)
                      & (state_q != ST_GRANT);
    assign take_src = cand_ext ? SRC_EXT : SRC_TMR;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (take) state_d = ST_GRANT;
            ST_GRANT:   state_d = ST_HANDLER;
            ST_HANDLER: begin
                if (take)                      state_d = ST_GRANT;
                else if (ret_en || ret_plain)  state_d = ST_IDLE;
            end
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            vec_q   <= '0;
        end else begin
            state_q <= state_d;
            if (take) vec_q <= (take_src == SRC_EXT) ? VEC_EXT : VEC_TMR;
        end
    end

    always_comb begin
        ack        = (state_q == ST_GRANT);
        in_handler = (state_q != ST_IDLE);
        vector     = vec_q;
    end

    // R7: acknowledge lasts one cycle
    p_ack_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);
    // R4: acknowledge only follows a tick
    p_ack_after_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> $past(phase_tick));
    // R8: full stack blocks the grant
    p_stack_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_tick && stack_full) |=> !ack);
    // R6: only the two defined vectors appear
    p_vec_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> (vector == VEC_EXT || vector == VEC_TMR));
    // R11: handler flag stays up right after acknowledge
    p_handler_after_ack_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> in_handler);
endmodule

// File: rtl/twin_irq_ctl.sv
module twin_irq_ctl
    import twin_irq_pkg::*;
#(
    parameter int               ADDR_W      = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR    = 8'h0B,
    parameter int               VEC_W       = 8,
    parameter logic [VEC_W-1:0] VEC_EXT     = 8'h04,
    parameter logic [VEC_W-1:0] VEC_TMR     = 8'h08,
    parameter int               SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_irq_n,
    input  logic              tmr_ovf,
    input  logic              phase_tick,
    input  logic              stack_full,
    input  logic              ret_en,
    input  logic              ret_plain,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [CTL_W-1:0]  reg_wdata,
    output logic [CTL_W-1:0]  reg_rdata,
    output logic              ack,
    output logic [VEC_W-1:0]  vector,
    output logic              in_handler
);
    logic             addr_hit, ext_fall, take;
    tic_src_e         take_src;
    logic [CTL_W-1:0] ctl;

    assign addr_hit  = (reg_addr == REG_ADDR);
    assign reg_rdata = addr_hit ? ctl : '0;

    tic_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .pin  (ext_irq_n),
        .fall (ext_fall)
    );

    tic_ctl_reg u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_we & addr_hit),
        .wdata    (reg_wdata),
        .ext_set  (ext_fall),
        .tmr_set  (tmr_ovf),
        .take     (take),
        .take_src (take_src),
        .ret_en   (ret_en),
        .ret_plain(ret_plain),
        .ctl_q    (ctl)
    );

    tic_grant_fsm #(.VEC_W(VEC_W), .VEC_EXT(VEC_EXT), .VEC_TMR(VEC_TMR)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase_tick(phase_tick),
        .stack_full(stack_full),
        .men       (ctl[B_MEN]),
        .ext_en    (ctl[B_EXTEN]),
        .tmr_en    (ctl[B_TMREN]),
        .ext_fl    (ctl[B_EXTFL]),
        .tmr_fl    (ctl[B_TMRFL]),
        .ret_en    (ret_en),
        .ret_plain (ret_plain),
        .take      (take),
        .take_src  (take_src),
        .ack       (ack),
        .vector    (vector),
        .in_handler(in_handler)
    );

    // R2: unused register bits never read as 1
    p_unused_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata & ~CTL_MASK) == '0);
    // R1: register is clear in the first cycle after reset
    p_reset_clear_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> (ctl == '0 && !ack));
endmodule

// File: tb/twin_irq_ctl_bench.sv
`timescale 1ns/1ps
module twin_irq_ctl_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ext_irq_n = 1'b1, tmr_ovf = 1'b0, phase_tick = 1'b0, stack_full = 1'b0;
    logic ret_en = 1'b0, ret_plain = 1'b0, reg_we = 1'b0;
    logic [7:0] reg_addr = 8'h0B, reg_wdata = 8'h00;
    logic [7:0] reg_rdata, vector;
    logic ack, in_handler;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_q[$];

    always #10 clk = ~clk;

    twin_irq_ctl u_twin_irq_ctl (
        .clk(clk), .rst_n(rst_n), .ext_irq_n(ext_irq_n), .tmr_ovf(tmr_ovf),
        .phase_tick(phase_tick), .stack_full(stack_full), .ret_en(ret_en),
        .ret_plain(ret_plain), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ack(ack),
        .vector(vector), .in_handler(in_handler)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: every acknowledge must match the next queued vector
    always @(negedge clk) begin
        if (rst_n && ack) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R5/R8: actual=ack vec %0h expected=no ack", vector);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                if (vector !== e) begin
                    errors++;
                    $display("FAIL R6: actual=%0h expected=%0h", vector, e);
                end
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_we = 1'b0; reg_addr = 8'h0B;
    endtask

    task automatic rd(input string tag, input logic [7:0] exp);
        @(negedge clk); #1;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic tmr_pulse();
        @(negedge clk); tmr_ovf = 1'b1;
        @(negedge clk); tmr_ovf = 1'b0;
    endtask

    task automatic ext_fall();
        @(negedge clk); ext_irq_n = 1'b0;
        repeat (5) @(negedge clk);
        ext_irq_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    // drive one tick; push the expected vector if a grant should follow
    task automatic tick(input string tag, input bit want, input logic [7:0] v);
        @(negedge clk); phase_tick = 1'b1;
        if (want) exp_q.push_back(v);
        @(negedge clk); phase_tick = 1'b0; #1;
        chk(tag, ack, want);
    endtask

    task automatic ret(input bit en);
        @(negedge clk); if (en) ret_en = 1'b1; else ret_plain = 1'b1;
        @(negedge clk); ret_en = 1'b0; ret_plain = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        rd("R1 reset reg", 8'h00);
        chk("R1 reset ack", ack, 0);
        chk("R1 reset handler", in_handler, 0);

        wr(8'h0B, 8'hFF);  rd("R2 layout", 8'h37);
        wr(8'h0B, 8'h00);  rd("R2 clear", 8'h00);
        wr(8'h0C, 8'hFF);  rd("R2 other addr write", 8'h00);
        @(negedge clk); reg_addr = 8'h0C; #1;
        chk("R2 other addr read", reg_rdata, 8'h00);
        reg_addr = 8'h0B;

        ext_fall();  rd("R3 ext flag", 8'h10);
        tmr_pulse(); rd("R3 tmr flag", 8'h30);

        wr(8'h0B, 8'h36);
        tick("R5 master off", 0, 8'h00);
        rd("R5 flags kept", 8'h36);

        wr(8'h0B, 8'h35);
        tick("R5 timer only", 1, 8'h08);
        rd("R7 clears", 8'h14);
        chk("R11 handler on", in_handler, 1);
        chk("R7 one cycle", ack, 0);
        ret(0);
        chk("R9 plain ends handler", in_handler, 0);
        rd("R9 plain keeps men", 8'h14);
        ret(1);
        rd("R9 ret_en sets men", 8'h15);
        tick("R5 ext disabled", 0, 8'h00);

        wr(8'h0B, 8'h37);
        tick("R6 priority", 1, 8'h04);
        rd("R6 tmr left", 8'h26);
        tick("R11 held", 0, 8'h00);
        wr(8'h0B, 8'h27);
        tick("R11 nested", 1, 8'h08);
        rd("R11 nested clear", 8'h06);
        ret(1);
        chk("R9 ret ends handler", in_handler, 0);

        tmr_pulse();
        stack_full = 1'b1;
        tick("R8 stack full", 0, 8'h00);
        rd("R8 flag kept", 8'h27);
        stack_full = 1'b0;
        tick("R8 released", 1, 8'h08);
        ret(1);

        @(negedge clk); tmr_ovf = 1'b1; phase_tick = 1'b1;
        @(negedge clk); tmr_ovf = 1'b0; phase_tick = 1'b0; #1;
        chk("R4 same-cycle flag waits", ack, 0);
        repeat (10) @(negedge clk);
        rd("R4 no tick no grant", 8'h27);
        tick("R4 next tick", 1, 8'h08);
        ret(1);

        @(negedge clk); reg_we = 1'b1; reg_wdata = 8'h05; tmr_ovf = 1'b1;
        @(negedge clk); reg_we = 1'b0; tmr_ovf = 1'b0;
        rd("R10 hw wins", 8'h25);
        tick("R10 grant", 1, 8'h08);
        ret(1);

        repeat (3) @(negedge clk);
        chk("R6 queue drained", exp_q.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule